// File: doc/BRIEF.md
# Quadrature Tap Selector

This block turns one sampled snapshot of a delay-line comparison into the tap numbers that a clock phase generator needs. Its input has one bit per candidate tap. A set bit means that the candidate tap lined up with a delay of exactly one reference-clock period. A line of `NUM_TAPS` taps offers only its lower half as candidates. Bit `k` of `hitVec` stands for tap `k+1`.

The block takes the earliest matching tap as the full-period (360 degree) point. It rounds an odd tap down to the nearest even tap and raises a request for one tap of delay compensation. It then derives the quarter, half and three-quarter taps from that point. When no candidate matches, the clock is too slow for the line and the block falls back to fixed quarter points of the whole line. When every candidate matches, the clock is too fast and the phase result is marked unusable. All results are captured on a latch strobe and held until the next one.

Top module: `quad_tap_selector`

## Requirements
- R1: The reported tap `tapHit` is `k+1`, where `k` is the lowest set bit of `hitVec`. Bit `k` maps to tap `k+1`, and candidates run from tap 1 to tap `NUM_TAPS/2`.
- R2: Set bits above the lowest set bit have no effect on any output.
- R3: When `hitVec` is all zero, `ovfFlag` is 1 and `tapHit` is 0. The phase taps are `NUM_TAPS/4`, `NUM_TAPS/2` and `3*NUM_TAPS/4`, and `oddFlag` and `compReq` are both 0.
- R4: When every bit of `hitVec` is set, `unfFlag` is 1. Otherwise `unfFlag` is 0.
- R5: When `tapHit` is odd, `oddFlag` and `compReq` are both 1, and the phase taps are derived from `tapHit-1`. When `tapHit` is even or 0, both flags are 0.
- R6: With a base `b` (the tap, rounded down to even), `tap90 = floor(b/4)`, `tap180 = b/2` and `tap270 = floor(3b/4)`.
- R7: All outputs change only on a rising clock edge that samples `latchEn` high. Otherwise they hold their values.
- R8: `phaseValid` is 1 exactly when both `ovfFlag` and `unfFlag` are 0.
- R9: While `rst` is high, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| latchEn | input | 1 | Capture strobe for a new result |
| hitVec | input | NUM_TAPS/2 | Candidate hit bits; bit k is tap k+1 |
| tapHit | output | $clog2(NUM_TAPS) | Selected full-period tap, 0 on overflow |
| tap90 | output | $clog2(NUM_TAPS) | Quarter-period tap |
| tap180 | output | $clog2(NUM_TAPS) | Half-period tap |
| tap270 | output | $clog2(NUM_TAPS) | Three-quarter-period tap |
| ovfFlag | output | 1 | No candidate matched |
| unfFlag | output | 1 | Every candidate matched |
| oddFlag | output | 1 | Selected tap was odd |
| compReq | output | 1 | One-tap delay compensation requested |
| phaseValid | output | 1 | Phase taps usable |

## Verification
The bench builds two copies of the block, one with 32 taps and one with 8. The 32-tap copy has 16 candidates, so it reaches taps that are not multiples of four and deep priority chains where the higher hits must be ignored. The 8-tap copy has only four candidates, so random stimulus often sets every bit. It also gives a small fallback set (2, 4, 6) and bases where truncation to zero happens.

// File: rtl/quad_tap_pkg.sv
package quad_tap_pkg;
  // Strobes from the decision logic to the result datapath
  typedef struct packed {
    logic load;      // capture a new result this cycle
    logic fallback;  // no candidate matched: use fixed quarter points
    logic invalid;   // every candidate matched
    logic comp;      // odd tap: round down and request compensation
  } tapStrobe_t;
endpackage

// File: rtl/quad_tap_prio.sv
module quad_tap_prio #(
  parameter int CAND = 16,
  parameter int IW   = 5
) (
  input  logic [CAND-1:0] hits,
  output logic            anyHit,
  output logic            allHit,
  output logic [IW-1:0]   firstTap
);
  logic [CAND:0]   noneBelow;
  logic [CAND-1:0] firstOh;

  assign noneBelow[0] = 1'b1;
  for (genvar i = 0; i < CAND; i++) begin : g_chain
    assign firstOh[i]     = hits[i] & noneBelow[i];
    assign noneBelow[i+1] = noneBelow[i] & ~hits[i];
  end

  always_comb begin
    firstTap = '0;
    for (int i = 0; i < CAND; i++) begin
      if (firstOh[i]) firstTap = firstTap | IW'(i + 1);
    end
  end

  assign anyHit = ~noneBelow[CAND];
  assign allHit = &hits;

  always_comb begin
    assert_first_onehot_R2: assert ($onehot0(firstOh));
  end
endmodule

// File: rtl/quad_tap_ctrl.sv
module quad_tap_ctrl
  import quad_tap_pkg::*;
(
  input  logic       latchEn,
  input  logic       anyHit,
  input  logic       allHit,
  input  logic       tapLsb,
  output tapStrobe_t strobe
);
  always_comb begin
    strobe.load     = latchEn;
    strobe.fallback = ~anyHit;
    strobe.invalid  = allHit;
    strobe.comp     = anyHit & tapLsb;
  end
endmodule

// File: rtl/quad_tap_datapath.sv
module quad_tap_datapath
  import quad_tap_pkg::*;
#(
  parameter int NUM_TAPS = 32,
  parameter int IW       = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  tapStrobe_t    strobe,
  input  logic [IW-1:0] firstTap,
  output logic [IW-1:0] tapHit,
  output logic [IW-1:0] tap90,
  output logic [IW-1:0] tap180,
  output logic [IW-1:0] tap270,
  output logic          ovfFlag,
  output logic          unfFlag,
  output logic          oddFlag,
  output logic          compReq,
  output logic          phaseValid
);
  localparam int WW = IW + 2;
  localparam logic [IW-1:0] FB90  = IW'(NUM_TAPS / 4);
  localparam logic [IW-1:0] FB180 = IW'(NUM_TAPS / 2);
  localparam logic [IW-1:0] FB270 = IW'((3 * NUM_TAPS) / 4);

  logic [IW-1:0] baseTap;
  logic [WW-1:0] triple;
  logic [IW-1:0] n90, n180, n270, nHit;

  always_comb begin
    baseTap = {firstTap[IW-1:1], 1'b0};
    triple  = WW'(baseTap) + (WW'(baseTap) << 1);
    if (strobe.fallback) begin
      nHit = '0;
      n90  = FB90;
      n180 = FB180;
      n270 = FB270;
    end else begin
      nHit = firstTap;
      n90  = baseTap >> 2;
      n180 = baseTap >> 1;
      n270 = IW'(triple >> 2);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tapHit     <= '0;
      tap90      <= '0;
      tap180     <= '0;
      tap270     <= '0;
      ovfFlag    <= 1'b0;
      unfFlag    <= 1'b0;
      oddFlag    <= 1'b0;
      compReq    <= 1'b0;
      phaseValid <= 1'b0;
    end else if (strobe.load) begin
      tapHit     <= nHit;
      tap90      <= n90;
      tap180     <= n180;
      tap270     <= n270;
      ovfFlag    <= strobe.fallback;
      unfFlag    <= strobe.invalid;
      oddFlag    <= strobe.comp;
      compReq    <= strobe.comp;
      phaseValid <= ~strobe.fallback & ~strobe.invalid;
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !strobe.load |=> $stable({tapHit, tap90, tap180, tap270, ovfFlag,
                              unfFlag, oddFlag, compReq, phaseValid}));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    ovfFlag |-> (tapHit == '0 && tap90 == FB90 && tap180 == FB180
                 && tap270 == FB270 && !compReq));

  assert_odd_comp_R5: assert property (@(posedge clk) disable iff (rst)
    compReq |-> (tapHit[0] && oddFlag && !ovfFlag));

  assert_half_tap_R6: assert property (@(posedge clk) disable iff (rst)
    !ovfFlag |-> (tap180 == (tapHit >> 1)));

  assert_valid_R8: assert property (@(posedge clk) disable iff (rst)
    phaseValid |-> (!ovfFlag && !unfFlag));
endmodule

// File: rtl/quad_tap_selector.sv
module quad_tap_selector
  import quad_tap_pkg::*;
#(
  parameter int NUM_TAPS = 32,
  localparam int CAND    = NUM_TAPS / 2,
  localparam int IW      = $clog2(NUM_TAPS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            latchEn,
  input  logic [CAND-1:0] hitVec,
  output logic [IW-1:0]   tapHit,
  output logic [IW-1:0]   tap90,
  output logic [IW-1:0]   tap180,
  output logic [IW-1:0]   tap270,
  output logic            ovfFlag,
  output logic            unfFlag,
  output logic            oddFlag,
  output logic            compReq,
  output logic            phaseValid
);
  logic          anyHit, allHit;
  logic [IW-1:0] firstTap;
  tapStrobe_t    strobe;

  quad_tap_prio #(.CAND(CAND), .IW(IW)) u_prio (
    .hits(hitVec), .anyHit(anyHit), .allHit(allHit), .firstTap(firstTap)
  );

  quad_tap_ctrl u_ctrl (
    .latchEn(latchEn), .anyHit(anyHit), .allHit(allHit),
    .tapLsb(firstTap[0]), .strobe(strobe)
  );

  quad_tap_datapath #(.NUM_TAPS(NUM_TAPS), .IW(IW)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .firstTap(firstTap),
    .tapHit(tapHit), .tap90(tap90), .tap180(tap180), .tap270(tap270),
    .ovfFlag(ovfFlag), .unfFlag(unfFlag), .oddFlag(oddFlag),
    .compReq(compReq), .phaseValid(phaseValid)
  );
endmodule

// File: tb/quad_tap_selector_bench.sv
module quad_tap_selector_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CYCLES     = 3000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic latA = 1'b0, latB = 1'b0;
  logic [15:0] hvA = '0;
  logic [3:0]  hvB = '0;
  int checks = 0, errors = 0;
  bit finished = 0;

  logic [4:0] aHit, a90, a180, a270;
  logic aOvf, aUnf, aOdd, aComp, aVal;
  logic [2:0] bHit, b90, b180, b270;
  logic bOvf, bUnf, bOdd, bComp, bVal;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_tap_selector #(.NUM_TAPS(32)) u_quad_tap_selector (
    .clk(clk), .rst(rst), .latchEn(latA), .hitVec(hvA),
    .tapHit(aHit), .tap90(a90), .tap180(a180), .tap270(a270),
    .ovfFlag(aOvf), .unfFlag(aUnf), .oddFlag(aOdd), .compReq(aComp),
    .phaseValid(aVal)
  );

  quad_tap_selector #(.NUM_TAPS(8)) u_quad_tap_selector_small (
    .clk(clk), .rst(rst), .latchEn(latB), .hitVec(hvB),
    .tapHit(bHit), .tap90(b90), .tap180(b180), .tap270(b270),
    .ovfFlag(bOvf), .unfFlag(bUnf), .oddFlag(bOdd), .compReq(bComp),
    .phaseValid(bVal)
  );

  // Expected values: 0 tap,1 q90,2 q180,3 q270,4 ovf,5 unf,6 odd,7 comp,8 valid
  int expA[9], expB[9];
  int heldA = 0, heldB = 0;

  function automatic void model(input int n, input int v, output int e[9]);
    int cand = n / 2;
    int tap = 0;
    int base;
    int mask = (1 << cand) - 1;
    for (int i = 0; i < cand; i++)
      if (v[i] && tap == 0) tap = i + 1;          // R1, R2: earliest hit only
    if (tap == 0) begin                           // R3 fallback
      e[0] = 0; e[1] = n / 4; e[2] = n / 2; e[3] = (3 * n) / 4;
      e[4] = 1; e[6] = 0; e[7] = 0;
    end else begin
      base = tap - (tap % 2);                     // R5 round down
      e[0] = tap; e[1] = base / 4; e[2] = base / 2; e[3] = (3 * base) / 4; // R6
      e[4] = 0; e[6] = tap % 2; e[7] = tap % 2;
    end
    e[5] = ((v & mask) == mask) ? 1 : 0;          // R4
    e[8] = (e[4] == 0 && e[5] == 0) ? 1 : 0;      // R8
  endfunction

  task automatic cmp(input string who, input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, who, act, exp, $time);
    end
  endtask

  task automatic checkAll(input string pre);
    string t[9] = '{"R1", "R6", "R6", "R6", "R3", "R4", "R5", "R5", "R8"};
    int actA[9] = '{aHit, a90, a180, a270, aOvf, aUnf, aOdd, aComp, aVal};
    int actB[9] = '{bHit, b90, b180, b270, bOvf, bUnf, bOdd, bComp, bVal};
    for (int k = 0; k < 9; k++) begin
      cmp("n32", (pre != "") ? pre : (heldA ? "R7" : t[k]), actA[k], expA[k]);
      cmp("n8",  (pre != "") ? pre : (heldB ? "R7" : t[k]), actB[k], expB[k]);
    end
  endtask

  function automatic int pick(input int cand);
    int mode = $urandom % 7;
    int v;
    case (mode)
      0: v = 0;
      1: v = (1 << cand) - 1;
      2: v = 1 << ($urandom % cand);
      3: v = $urandom & ((1 << cand) - 1) & $urandom;
      default: v = $urandom & ((1 << cand) - 1);
    endcase
    return v;
  endfunction

  task automatic drive(input int va, input int vb, input bit la, input bit lb);
    hvA = 16'(va); hvB = 4'(vb); latA = la; latB = lb;
    heldA = !la; heldB = !lb;
    if (la) model(32, va, expA);
    if (lb) model(8, vb, expB);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 9; k++) begin expA[k] = 0; expB[k] = 0; end
    latA = 1'b1; latB = 1'b1; hvA = 16'h0001; hvB = 4'h1;
    repeat (3) @(negedge clk);
    checkAll("R9");                               // reset holds zero despite latch
    rst = 1'b0;
    drive(0, 0, 1, 1);                            // still reset state expected now
    for (int k = 0; k < 9; k++) begin expA[k] = 0; expB[k] = 0; end
    model(32, 0, expA); model(8, 0, expB);
    // directed patterns, each followed by a check one cycle later
    @(negedge clk); checkAll("");                 // R3 overflow
    drive(16'hFFFF, 4'hF, 1, 1);                  // R4 all hit
    @(negedge clk); checkAll("");
    drive(16'h0020, 4'h4, 1, 1);                  // tap 6 / tap 3 (R5 odd on n8)
    @(negedge clk); checkAll("");
    drive(16'hF040, 4'hC, 1, 1);                  // R2: taps 7 and higher; tap 3
    @(negedge clk); checkAll("");
    drive(16'h8000, 4'h8, 1, 1);                  // highest candidate only
    @(negedge clk); checkAll("");
    drive(16'h0000, 4'h0, 0, 0);                  // R7: hold with latch low
    @(negedge clk); checkAll("");
    drive(16'h0004, 4'h2, 1, 1);                  // tap 3 / tap 2
    @(negedge clk); checkAll("");
    for (int c = 0; c < CYCLES; c++) begin
      drive(pick(16), pick(4), ($urandom % 4) != 0, ($urandom % 4) != 0);
      @(negedge clk); checkAll("");
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule